// File: doc/BRIEF.md
# Ethernet Transmit Handshake and Preamble Serializer

This block sits at the front of a 10 Mbit/s Ethernet transmit path and runs on the transmit bit clock. A host raises a request and the block answers with an acknowledge. The block then waits for an external start-permit input, which carries the interframe-gap decision made elsewhere. Once the permit is seen, it emits a one-clock start strobe. It then shifts out an alternating preamble of selectable length, the start-frame delimiter, and the host's bytes, one bit per clock, least significant bit first.

The host supplies each next byte when the block pulses a load strobe. It flags the final byte with an end-of-data bit. After the final bit the block pulses an end-of-packet strobe and releases the acknowledge. Three separate abort inputs (excessive collisions, excessive deferral, host abort) stop the frame at the next clock edge and produce a one-clock aborted pulse. A withdrawn request ends the frame silently. The block adds no address, no padding and no CRC: every bit after the delimiter comes straight from the host.

Top module: `eth_tx_front`

## Requirements
- R1: `ack_o` rises one clock after `req_i` is sampled high in idle, but only if `req_i` was sampled low during at least one idle clock since reset or since the end of the previous frame; a request held high through the end of a frame does not re-raise `ack_o`.
- R2: While `ack_o` is high and `start_ok_i` is low, `busy_o` and `txd_o` stay low and no start strobe is issued.
- R3: `sop_o` is high for exactly one clock, the clock immediately before the first preamble bit, and `busy_o` is low during it.
- R4: The preamble is 32 + 8*sel bits long (sel = `pre_sel_i` as sampled at the end of the `sop_o` clock: 0->32, 1->40, 2->48, 3->56), alternating 1,0,1,0... starting with 1; changing `pre_sel_i` later has no effect on the current frame.
- R5: The 8 delimiter bits follow the preamble directly, sent in the order 1,0,1,0,1,0,1,1.
- R6: Host bytes follow the delimiter with nothing inserted, each sent least significant bit first; `busy_o` is high exactly on clocks that carry a frame bit, and `txd_o` is low whenever `busy_o` is low.
- R7: `load_o` is high during the seventh bit (bit index 6) of the delimiter and of every data byte except the final one; `byte_i` and `last_i` are sampled at the clock edge that ends that clock; a frame with N bytes gives exactly N load strobes.
- R8: On the clock after the final data bit, `eop_o` is high for one clock and `ack_o` is already low.
- R9: If any of `abort_host_i`, `abort_coll_i`, `abort_defer_i` is high at a clock edge while `ack_o` is high, then from that edge on no more bits are sent, `aborted_o` is high for exactly one clock, `ack_o` is low, and no `eop_o` follows.
- R10: If `req_i` is low at a clock edge while `ack_o` is high and no abort input is high, `ack_o` falls and transmission stops at that edge without `aborted_o`; when both happen together the abort wins and `aborted_o` pulses.
- R11: Abort inputs are ignored while `ack_o` is low, including the `eop_o` clock: no `aborted_o` pulse results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Host transmit request |
| start_ok_i | input | 1 | Start permit from the interframe-gap logic |
| pre_sel_i | input | 2 | Preamble length select (32/40/48/56 bits) |
| byte_i | input | 8 | Next host data byte |
| last_i | input | 1 | Marks `byte_i` as the final byte of the frame |
| abort_host_i | input | 1 | Host-requested abort |
| abort_coll_i | input | 1 | Excessive-collision abort |
| abort_defer_i | input | 1 | Excessive-deferral abort |
| ack_o | output | 1 | Request acknowledge |
| sop_o | output | 1 | One-clock start strobe before the preamble |
| busy_o | output | 1 | High on every clock carrying a frame bit |
| txd_o | output | 1 | Serial transmit data |
| load_o | output | 1 | Request for the next host byte |
| eop_o | output | 1 | One-clock end-of-packet strobe |
| aborted_o | output | 1 | One-clock pulse after an abort |

## Verification
Two functions can meet in one clock: an abort request can land on the clock of the very last data bit, where normal completion would otherwise take over, or on the end-of-packet clock itself. The bench provokes the first by raising an abort input exactly when its captured bit count reaches the frame length, and it expects an aborted pulse with no end-of-packet strobe. It provokes the second by raising an abort on the clock where it sees `eop_o`, and it expects a clean completion with no aborted pulse. A simultaneous abort and request withdrawal is also driven, and the abort must take priority.

// File: rtl/eth_tx_pkg.sv
package eth_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_WAIT = 3'd1,
        ST_SOP  = 3'd2,
        ST_PRE  = 3'd3,
        ST_SFD  = 3'd4,
        ST_DATA = 3'd5,
        ST_END  = 3'd6
    } tx_state_e;

endpackage

// File: rtl/eth_tx_shifter.sv
module eth_tx_shifter #(
    parameter int DW = 8,
    localparam int IDX_W = $clog2(DW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [DW-1:0]    val_i,
    input  logic             run_i,
    output logic             bit_o,
    output logic [IDX_W-1:0] idx_o
);

    typedef struct packed {
        logic [DW-1:0]    sh;
        logic [IDX_W-1:0] idx;
    } shf_t;

    shf_t d, q;

    always_comb begin
        d = q;
        if (load_i) begin
            d.sh  = val_i;
            d.idx = '0;
        end else if (run_i) begin
            d.sh  = {1'b0, q.sh[DW-1:1]};
            d.idx = q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bit_o = q.sh[0];
    assign idx_o = q.idx;

    // R6: a freshly loaded byte presents its least significant bit first
    p_load_lsb_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (bit_o == $past(val_i[0])) && (idx_o == '0));

    // R6: each shifted clock advances to the next higher bit of the byte
    p_shift_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !load_i) |=> (bit_o == $past(q.sh[1])));

endmodule

// File: rtl/eth_tx_ctrl.sv
module eth_tx_ctrl
    import eth_tx_pkg::*;
#(
    parameter int DW       = 8,
    parameter int SEL_W    = 2,
    parameter int PRE_BASE = 4,
    localparam int IDX_W   = $clog2(DW),
    localparam int PCNT_W  = $clog2(PRE_BASE + (1 << SEL_W))
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic             start_ok_i,
    input  logic [SEL_W-1:0] pre_sel_i,
    input  logic [DW-1:0]    byte_i,
    input  logic             last_i,
    input  logic             abort_any_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic             ack_o,
    output logic             sop_o,
    output logic             busy_o,
    output logic             load_o,
    output logic             eop_o,
    output logic             aborted_o,
    output logic             sh_load_o,
    output logic [DW-1:0]    sh_val_o,
    output logic             sh_run_o
);

    localparam logic [DW-1:0] PRE_PAT = {(DW/2){2'b01}};
    localparam logic [DW-1:0] SFD_PAT = PRE_PAT | (DW'(1) << (DW-1));
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DW-1);
    localparam logic [IDX_W-1:0] IDX_LOAD = IDX_W'(DW-2);

    typedef struct packed {
        tx_state_e         st;
        logic              armed;
        logic              abrt;
        logic [SEL_W-1:0]  sel;
        logic [PCNT_W-1:0] pcnt;
        logic [DW-1:0]     nb;
        logic              nl;
        logic              cl;
    } ctl_t;

    ctl_t d, q;
    logic active;
    logic bit_last;

    assign bit_last = (idx_i == IDX_LAST);
    assign active   = (q.st == ST_WAIT) || (q.st == ST_SOP) || (q.st == ST_PRE) ||
                      (q.st == ST_SFD)  || (q.st == ST_DATA);

    always_comb begin
        d         = q;
        d.abrt    = 1'b0;
        sh_load_o = 1'b0;
        sh_val_o  = PRE_PAT;
        load_o    = (idx_i == IDX_LOAD) &&
                    ((q.st == ST_SFD) || ((q.st == ST_DATA) && !q.cl));

        if (active && abort_any_i) begin
            d.st   = ST_IDLE;
            d.abrt = 1'b1;
        end else if (active && !req_i) begin
            d.st = ST_IDLE;
        end else begin
            unique case (q.st)
                ST_IDLE: begin
                    d.armed = !req_i;
                    if (req_i && q.armed) begin
                        d.st    = ST_WAIT;
                        d.armed = 1'b0;
                    end
                end
                ST_WAIT: begin
                    if (start_ok_i) d.st = ST_SOP;
                end
                ST_SOP: begin
                    sh_load_o = 1'b1;
                    sh_val_o  = PRE_PAT;
                    d.sel     = pre_sel_i;
                    d.pcnt    = '0;
                    d.st      = ST_PRE;
                end
                ST_PRE: begin
                    if (bit_last) begin
                        sh_load_o = 1'b1;
                        if (int'(q.pcnt) == PRE_BASE - 1 + int'(q.sel)) begin
                            sh_val_o = SFD_PAT;
                            d.st     = ST_SFD;
                        end else begin
                            sh_val_o = PRE_PAT;
                            d.pcnt   = q.pcnt + 1'b1;
                        end
                    end
                end
                ST_SFD, ST_DATA: begin
                    if (load_o) begin
                        d.nb = byte_i;
                        d.nl = last_i;
                    end
                    if (bit_last) begin
                        if ((q.st == ST_DATA) && q.cl) begin
                            d.st = ST_END;
                        end else begin
                            sh_load_o = 1'b1;
                            sh_val_o  = q.nb;
                            d.cl      = q.nl;
                            d.st      = ST_DATA;
                        end
                    end
                end
                ST_END: begin
                    d.st    = ST_IDLE;
                    d.armed = 1'b0;
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign ack_o     = active;
    assign sop_o     = (q.st == ST_SOP);
    assign busy_o    = (q.st == ST_PRE) || (q.st == ST_SFD) || (q.st == ST_DATA);
    assign eop_o     = (q.st == ST_END);
    assign aborted_o = q.abrt;
    assign sh_run_o  = busy_o && !sh_load_o;

    // R3: the start strobe lasts one clock
    p_sop_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sop_o |=> !sop_o);

    // R3: an uninterrupted start strobe is followed by the first bit
    p_sop_then_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sop_o && req_i && !abort_any_i) |=> busy_o);

    // R6: bits are only sent under an acknowledged request
    p_busy_has_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> ack_o);

    // R8: end-of-packet comes with the acknowledge already released
    p_eop_no_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        eop_o |-> !ack_o);

    // R1: a request still held after completion is not acknowledged again
    p_no_reack_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (eop_o && req_i) |=> !ack_o);

    // R9: any abort ends the frame at the next edge with one aborted pulse
    p_abort_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && abort_any_i) |=> (aborted_o && !ack_o && !busy_o && !eop_o));

    // R9: the aborted indication is a single-clock pulse
    p_abort_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        aborted_o |=> !aborted_o);

    // R10: withdrawing the request stops quietly
    p_req_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && !req_i && !abort_any_i) |=> (!ack_o && !aborted_o && !busy_o));

    // R11: aborts outside an acknowledged request produce no pulse
    p_abort_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_o |=> !aborted_o);

endmodule

// File: rtl/eth_tx_front.sv
module eth_tx_front #(
    parameter int DW       = 8,
    parameter int SEL_W    = 2,
    parameter int PRE_BASE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic             start_ok_i,
    input  logic [SEL_W-1:0] pre_sel_i,
    input  logic [DW-1:0]    byte_i,
    input  logic             last_i,
    input  logic             abort_host_i,
    input  logic             abort_coll_i,
    input  logic             abort_defer_i,
    output logic             ack_o,
    output logic             sop_o,
    output logic             busy_o,
    output logic             txd_o,
    output logic             load_o,
    output logic             eop_o,
    output logic             aborted_o
);

    localparam int IDX_W = $clog2(DW);

    logic             abort_any;
    logic             sh_load;
    logic [DW-1:0]    sh_val;
    logic             sh_run;
    logic             sh_bit;
    logic [IDX_W-1:0] sh_idx;

    assign abort_any = abort_host_i | abort_coll_i | abort_defer_i;

    eth_tx_ctrl #(
        .DW       (DW),
        .SEL_W    (SEL_W),
        .PRE_BASE (PRE_BASE)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req_i),
        .start_ok_i  (start_ok_i),
        .pre_sel_i   (pre_sel_i),
        .byte_i      (byte_i),
        .last_i      (last_i),
        .abort_any_i (abort_any),
        .idx_i       (sh_idx),
        .ack_o       (ack_o),
        .sop_o       (sop_o),
        .busy_o      (busy_o),
        .load_o      (load_o),
        .eop_o       (eop_o),
        .aborted_o   (aborted_o),
        .sh_load_o   (sh_load),
        .sh_val_o    (sh_val),
        .sh_run_o    (sh_run)
    );

    eth_tx_shifter #(
        .DW (DW)
    ) u_shf (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (sh_load),
        .val_i  (sh_val),
        .run_i  (sh_run),
        .bit_o  (sh_bit),
        .idx_o  (sh_idx)
    );

    assign txd_o = busy_o & sh_bit;

    // R6: the line stays low outside frame bits
    p_idle_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !txd_o);

endmodule

// File: tb/sim_eth_tx_front.sv
`timescale 1ns/1ps
module sim_eth_tx_front;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0, start_ok = 1'b0, last = 1'b0;
    logic [1:0] pre_sel = 2'd0;
    logic [7:0] byte_in = 8'd0;
    logic ab_host = 1'b0, ab_coll = 1'b0, ab_defer = 1'b0;
    logic ack, sop, busy, txd, load, eop, aborted;

    always #5 clk = ~clk;

    eth_tx_front u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req), .start_ok_i(start_ok),
        .pre_sel_i(pre_sel), .byte_i(byte_in), .last_i(last),
        .abort_host_i(ab_host), .abort_coll_i(ab_coll), .abort_defer_i(ab_defer),
        .ack_o(ack), .sop_o(sop), .busy_o(busy), .txd_o(txd), .load_o(load),
        .eop_o(eop), .aborted_o(aborted)
    );

    int nchk = 0, nfail = 0;
    int cyc = 0;
    logic cap [0:1023];
    int ncap, nload, nsop, neop, nab;
    int load_idx [0:63];
    int sop_cyc, first_busy, last_busy, eop_cyc, ab_cyc, ack_last;
    logic ack_eop, ack_ab, reack, idle_txd;
    logic [7:0] frame [0:63];
    int nbytes, fi;

    task automatic chk(input logic ok, input string rq, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    function automatic logic exp_bit(input int idx, input int sel);
        int p = 32 + 8 * sel;
        logic [7:0] sfd = 8'b1101_0101;
        if (idx < p) return (idx % 2 == 0);
        if (idx < p + 8) return sfd[idx - p];
        return frame[(idx - p - 8) / 8][(idx - p - 8) % 8];
    endfunction

    // monitor and host byte feeder, both acting at the falling edge
    always @(negedge clk) begin
        cyc++;
        if (busy) begin
            cap[ncap] = txd;
            if (ncap == 0) first_busy = cyc;
            last_busy = cyc;
            ncap++;
        end else if (txd) idle_txd = 1'b1;
        if (sop) begin nsop++; sop_cyc = cyc; end
        if (eop) begin neop++; eop_cyc = cyc; ack_eop = ack; end
        if (aborted) begin nab++; ab_cyc = cyc; ack_ab = ack; end
        if (ack) begin
            ack_last = cyc;
            if (neop > 0) reack = 1'b1;
        end
        if (load) begin
            if (nload < 64) load_idx[nload] = ncap - 1;
            nload++;
            byte_in = frame[fi];
            last = (fi == nbytes - 1);
            if (fi < 63) fi++;
        end
    end

    task automatic clear_mon();
        ncap = 0; nload = 0; nsop = 0; neop = 0; nab = 0; fi = 0;
        sop_cyc = -1; first_busy = -1; last_busy = -1; eop_cyc = -1; ab_cyc = -1; ack_last = -1;
        ack_eop = 1'b1; ack_ab = 1'b1; reack = 1'b0; idle_txd = 1'b0;
    endtask

    // mode: 0 normal, 1 host abort, 2 collision abort, 3 deferral abort,
    // 4 request drop, 5 abort on end-of-packet clock, 6 select change mid-frame,
    // 7 deferral abort together with request drop
    task automatic frame_run(input int sel, input int n, input int mode, input int k);
        int total = 32 + 8 * sel + 8 + 8 * n;
        int hold = $urandom % 4;
        int exp_len;
        logic fired = 1'b0;
        logic cut;
        int bad;
        cut = (mode >= 1 && mode <= 4) || mode == 7;
        exp_len = cut ? k : total;
        nbytes = n;
        for (int i = 0; i < n; i++) frame[i] = 8'($urandom);
        @(negedge clk); #1;
        clear_mon();
        pre_sel = 2'(sel); req = 1'b1; start_ok = 1'b0;
        @(negedge clk); #1;
        chk(ack == 1'b1, "R1 ack after request", int'(ack), 1);
        for (int h = 0; h < hold; h++) begin
            @(negedge clk); #1;
            chk(!busy && !txd && !sop && ack, "R2 waits for start permit", int'({busy, txd, sop}), 0);
        end
        start_ok = 1'b1;
        for (int c = 0; c < total + 12; c++) begin
            @(negedge clk); #1;
            if (mode == 6 && ncap > 0) pre_sel = ~2'(sel);
            if (cut && !fired && ncap >= k) begin
                fired = 1'b1;
                case (mode)
                    1: ab_host = 1'b1;
                    2: ab_coll = 1'b1;
                    3: ab_defer = 1'b1;
                    4: req = 1'b0;
                    default: begin ab_defer = 1'b1; req = 1'b0; end
                endcase
            end else if (mode == 5 && !fired && neop > 0) begin
                fired = 1'b1;
                ab_host = 1'b1;
            end else begin
                ab_host = 1'b0; ab_coll = 1'b0; ab_defer = 1'b0;
            end
        end
        ab_host = 1'b0; ab_coll = 1'b0; ab_defer = 1'b0;
        req = 1'b0; start_ok = 1'b0;
        @(negedge clk); #1;
        @(negedge clk); #1;

        chk(ncap == exp_len, "R4/R9 bit count", ncap, exp_len);
        bad = -1;
        for (int i = 0; i < ncap && i < 32 + 8 * sel; i++)
            if (bad < 0 && cap[i] !== exp_bit(i, sel)) bad = i;
        chk(bad < 0, "R4 preamble bits", bad, -1);
        bad = -1;
        for (int i = 32 + 8 * sel; i < ncap && i < 40 + 8 * sel; i++)
            if (bad < 0 && cap[i] !== exp_bit(i, sel)) bad = i;
        chk(bad < 0, "R5 delimiter bits", bad, -1);
        bad = -1;
        for (int i = 40 + 8 * sel; i < ncap; i++)
            if (bad < 0 && cap[i] !== exp_bit(i, sel)) bad = i;
        chk(bad < 0, "R6 data bits lsb first", bad, -1);
        chk(!idle_txd, "R6 line low when not busy", int'(idle_txd), 0);
        chk(nsop == 1 && sop_cyc == first_busy - 1, "R3 start strobe", sop_cyc, first_busy - 1);
        chk(ack_last == last_busy, "R8/R9/R10 ack release", ack_last, last_busy);

        if (!cut) begin
            chk(nload == n, "R7 load count", nload, n);
            bad = -1;
            for (int j = 0; j < n && j < nload; j++)
                if (bad < 0 && load_idx[j] != 32 + 8 * sel + 6 + 8 * j) bad = j;
            chk(bad < 0, "R7 load position", bad, -1);
            chk(neop == 1 && eop_cyc == last_busy + 1, "R8 end strobe", eop_cyc, last_busy + 1);
            chk(ack_eop == 1'b0, "R8 ack low at end", int'(ack_eop), 0);
            chk(nab == 0, "R11 no aborted pulse", nab, 0);
            chk(!reack, "R1 no re-ack while held", int'(reack), 0);
        end else if (mode == 4) begin
            chk(nab == 0 && neop == 0, "R10 quiet stop", nab + neop, 0);
        end else begin
            chk(nab == 1 && ab_cyc == last_busy + 1, "R9 aborted pulse", ab_cyc, last_busy + 1);
            chk(neop == 0 && ack_ab == 1'b0, "R9 no end strobe", neop, 0);
        end
    endtask

    initial begin
        #1500000;
        nfail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'd7741));
        clear_mon();
        req = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk(!ack && !sop && !busy && !txd && !load && !eop && !aborted, "R1 reset state",
            int'({ack, sop, busy, txd, load, eop, aborted}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk(!ack, "R1 request held from reset not acked", int'(ack), 0);
        req = 1'b0;
        repeat (2) @(negedge clk);

        for (int s = 0; s < 4; s++) frame_run(s, 1 + s % 2, 0, 0);
        frame_run(1, 3, 6, 0);
        for (int r = 0; r < 12; r++) frame_run(int'($urandom % 4), 1 + int'($urandom % 6), 0, 0);
        for (int m = 1; m <= 4; m++) frame_run(m - 1, 2, m, 1 + int'($urandom % 50));
        frame_run(2, 2, 7, 20);
        frame_run(0, 2, 1, 56);
        frame_run(3, 1, 2, 72);
        frame_run(1, 2, 5, 0);

        // R9: abort while still waiting for the start permit
        @(negedge clk); #1;
        clear_mon();
        req = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        ab_coll = 1'b1;
        @(negedge clk); #1;
        ab_coll = 1'b0;
        chk(aborted && !ack && nsop == 0, "R9 abort during wait", int'({aborted, ack}), 2);
        req = 1'b0;
        repeat (3) @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule